// File: doc/BRIEF.md
# Supervisor Reset Sequencer

This block produces the active-low system reset for a board-level supervisor. Power-good flags arrive as plain logic from external comparators. The block holds reset low from its own reset until every monitored channel reports good. It then times a release delay and only after that drives reset high. A 2-bit select input chooses one of four release delays. The set of lengths is uneven, from a tenth of a second up to five seconds.

A manual reset input can restart the whole sequence at any time. A pulse on that input counts only if it stays high for at least five microseconds. Shorter pulses are treated as noise. Every asynchronous input passes through a two-flop synchroniser. Two parameters set all timing: clock cycles per microsecond and microseconds per millisecond. A bench can scale the second one down so that the long delays fit a short run.

Top module: `rst_sequencer`

## Requirements
- R1: While `rst` is high, and right after it is released, `sys_rst_n` is 0.
- R2: `sys_rst_n` stays 0 for as long as any bit of `pwr_good` is 0, and the release delay does not run during that time.
- R3: Once every bit of `pwr_good` is 1 and `man_rst` is 0, `sys_rst_n` goes to 1 after the selected delay and not before it (latency: the delay plus 2 to 5 cycles).
- R4: The `dly_sel` code sets the delay as follows: 2'b00 = 100 ms (the reset-time default), 2'b01 = 500 ms, 2'b10 = 1 s, 2'b11 = 5 s. One millisecond is US_PER_MS*CLK_PER_US cycles.
- R5: A `man_rst` high pulse that lasts at least MR_MIN_US*CLK_PER_US cycles (5 µs by default) drives `sys_rst_n` to 0. It stays 0 while the pulse lasts.
- R6: A `man_rst` pulse shorter than MR_MIN_US*CLK_PER_US cycles leaves `sys_rst_n` unchanged.
- R7: If any `pwr_good` bit falls during the delay or after release, `sys_rst_n` goes back to 0. The delay then restarts from zero once all bits are good again.
- R8: After a qualified manual reset pulse ends, the full selected delay runs again before release.
- R9: `dly_sel` is captured when the delay starts. A change while the delay is running has no effect until the next reset cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock, CLK_PER_US cycles per microsecond |
| rst | input | 1 | Synchronous active-high block reset |
| pwr_good | input | NUM_CH | Power-good flag per monitored channel, 1 = good |
| man_rst | input | 1 | Manual reset request, active high, asynchronous |
| dly_sel | input | 2 | Release-delay code from the control register |
| sys_rst_n | output | 1 | Registered system reset, 0 = reset asserted |

## Verification
An input change reaches the sequencer two cycles later, after the synchroniser. The manual-reset qualifier adds one more cycle, and the output register adds one more. Every change in `sys_rst_n` is therefore due a fixed two to five cycles after its cause. For assertion, the bench samples on the falling edge four to five cycles after the stimulus. For release, it checks that reset is still low two cycles before the delay count ends and is high six cycles after it. This window covers every register on the path. The "no effect" cases (a short pulse, a bad channel, a late select change) are checked at each falling edge over the whole interval where a wrong release or assertion could appear.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  typedef enum logic [1:0] {
    SEQ_HOLD  = 2'd0,
    SEQ_COUNT = 2'd1,
    SEQ_RUN   = 2'd2
  } seq_state_e;

  // Release delay in milliseconds for each select code.
  function automatic longint unsigned dly_ms(input logic [1:0] sel);
    case (sel)
      2'b00:   return 64'd100;
      2'b01:   return 64'd500;
      2'b10:   return 64'd1000;
      default: return 64'd5000;
    endcase
  endfunction

  localparam longint unsigned DLY_MS_MAX = 64'd5000;
  localparam longint unsigned DLY_MS_MIN = 64'd100;

endpackage

// File: rtl/rstseq_sync2.sv
module rstseq_sync2 #(
  parameter int W = 1,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic sync_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= d[i];
        sync_q <= meta_q;
      end
    end
    assign q[i] = sync_q;
  end

endmodule

// File: rtl/rstseq_mr_filter.sv
module rstseq_mr_filter #(
  parameter int MIN_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic mr_s,
  output logic mr_act
);

  localparam int CW = (MIN_CYC > 1) ? $clog2(MIN_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          full;

  assign full = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      mr_act <= 1'b0;
    end else begin
      if (!mr_s) begin
        cnt_q <= '0;
      end else if (!full) begin
        cnt_q <= cnt_q + 1'b1;
      end
      mr_act <= mr_s && full;
    end
  end

endmodule

// File: rtl/rstseq_delay_timer.sv
module rstseq_delay_timer #(
  parameter int              CNT_W      = 32,
  parameter longint unsigned CYC_PER_MS = 64'd1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       done
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim_q;

  assign done = (cnt_q == lim_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(rstseq_pkg::DLY_MS_MIN * CYC_PER_MS);
    end else if (load) begin
      cnt_q <= '0;
      lim_q <= CNT_W'(rstseq_pkg::dly_ms(sel) * CYC_PER_MS);
    end else if (run) begin
      cnt_q <= cnt_q + 1'b1;
    end else begin
      cnt_q <= '0;
    end
  end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int NUM_CH     = 2,
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000,
  parameter int MR_MIN_US  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pwr_good,
  input  logic              man_rst,
  input  logic [1:0]        dly_sel,
  output logic              sys_rst_n
);

  import rstseq_pkg::*;

  localparam longint unsigned CYC_PER_MS = longint'(CLK_PER_US) * longint'(US_PER_MS);
  localparam longint unsigned MAX_CYC    = DLY_MS_MAX * CYC_PER_MS;
  localparam int              CNT_W      = $clog2(MAX_CYC + 1);
  localparam int              MR_CYC     = MR_MIN_US * CLK_PER_US;

  logic [NUM_CH-1:0] pg_sync;
  logic              mr_sync;
  logic              mr_act;
  logic              all_good;
  logic              stop;
  logic              t_load;
  logic              t_run;
  logic              t_done;
  seq_state_e        state_q;
  seq_state_e        state_d;

  rstseq_sync2 #(.W(NUM_CH), .RST_VAL(1'b0)) u_pg_sync (
    .clk(clk), .rst(rst), .d(pwr_good), .q(pg_sync)
  );

  rstseq_sync2 #(.W(1), .RST_VAL(1'b0)) u_mr_sync (
    .clk(clk), .rst(rst), .d(man_rst), .q(mr_sync)
  );

  rstseq_mr_filter #(.MIN_CYC(MR_CYC)) u_mr_filt (
    .clk(clk), .rst(rst), .mr_s(mr_sync), .mr_act(mr_act)
  );

  rstseq_delay_timer #(.CNT_W(CNT_W), .CYC_PER_MS(CYC_PER_MS)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .run(t_run), .sel(dly_sel), .done(t_done)
  );

  assign all_good = &pg_sync;
  assign stop     = !all_good || mr_act;

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_run   = 1'b0;
    case (state_q)
      SEQ_HOLD: begin
        if (!stop) begin
          state_d = SEQ_COUNT;
          t_load  = 1'b1;
        end
      end
      SEQ_COUNT: begin
        if (stop) begin
          state_d = SEQ_HOLD;
        end else if (t_done) begin
          state_d = SEQ_RUN;
        end else begin
          t_run = 1'b1;
        end
      end
      SEQ_RUN: begin
        if (stop) state_d = SEQ_HOLD;
      end
      default: state_d = SEQ_HOLD;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SEQ_HOLD;
      sys_rst_n <= 1'b0;
    end else begin
      state_q   <= state_d;
      sys_rst_n <= (state_d == SEQ_RUN);
    end
  end

endmodule

// File: rtl/rstseq_checker.sv
module rstseq_checker #(
  parameter int NUM_CH     = 2,
  parameter int CLK_PER_US = 125,
  parameter int US_PER_MS  = 1000
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_CH-1:0] pg_sync,
  input logic              mr_act,
  input logic              sys_rst_n
);

  localparam longint unsigned MIN_LIM = 64'd100 * longint'(CLK_PER_US) * longint'(US_PER_MS);
  localparam int              RW      = $clog2(MIN_LIM + 2);

  logic          ok_now;
  logic [RW-1:0] run_q;

  assign ok_now = (&pg_sync) && !mr_act;

  always_ff @(posedge clk) begin
    if (rst || !ok_now) run_q <= '0;
    else if (run_q != RW'(MIN_LIM + 1)) run_q <= run_q + 1'b1;
  end

  a_r1_reset_low: assert property (@(posedge clk) rst |=> !sys_rst_n);

  a_r2_bad_channel_low: assert property (@(posedge clk) disable iff (rst)
    !(&pg_sync) |=> !sys_rst_n);

  a_r5_manual_low: assert property (@(posedge clk) disable iff (rst)
    mr_act |=> !sys_rst_n);

  a_r3_release_after_good: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> $past(ok_now));

  // R3, R7: release only after at least the shortest delay of clean input
  a_r7_min_clean_run: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_rst_n) |-> (run_q >= RW'(MIN_LIM)));

endmodule

bind rst_sequencer rstseq_checker #(
  .NUM_CH(NUM_CH), .CLK_PER_US(CLK_PER_US), .US_PER_MS(US_PER_MS)
) u_chk (
  .clk(clk), .rst(rst), .pg_sync(pg_sync), .mr_act(mr_act), .sys_rst_n(sys_rst_n)
);

// File: tb/sim_rst_sequencer.sv
module sim_rst_sequencer;

  localparam int NCH  = 2;
  localparam int CPU  = 2;
  localparam int UPM  = 1;
  localparam int MRUS = 5;
  localparam int MRC  = MRUS * CPU;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] pg  = '0;
  logic           mr  = 1'b0;
  logic [1:0]     sel = 2'b00;
  logic           rst_n;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rst_sequencer #(.NUM_CH(NCH), .CLK_PER_US(CPU), .US_PER_MS(UPM), .MR_MIN_US(MRUS)) u0 (
    .clk(clk), .rst(rst), .pwr_good(pg), .man_rst(mr), .dly_sel(sel), .sys_rst_n(rst_n)
  );

  function automatic int exp_delay(input logic [1:0] s);
    int ms;
    case (s)
      2'b00:   ms = 100;
      2'b01:   ms = 500;
      2'b10:   ms = 1000;
      default: ms = 5000;
    endcase
    return ms * UPM * CPU;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic exp);
    checks++;
    if (rst_n !== exp) begin
      errs++;
      $display("FAIL %s: sys_rst_n=%0b expected %0b", tag, rst_n, exp);
    end
  endtask

  task automatic hold_check(input string tag, input int n, input logic exp);
    logic bad = 1'b0;
    logic seen = exp;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (rst_n !== exp && !bad) begin
        bad = 1'b1;
        seen = rst_n;
      end
    end
    checks++;
    if (bad) begin
      errs++;
      $display("FAIL %s: sys_rst_n=%0b expected %0b held", tag, seen, exp);
    end
  endtask

  // Cause of release happened at the previous negedge; 'used' cycles already stepped.
  task automatic release_check(input string tag, input logic [1:0] s, input int used);
    int l = exp_delay(s);
    step(l - 2 - used);
    check({tag, " early"}, 1'b0);
    step(8);
    check({tag, " release"}, 1'b1);
  endtask

  task automatic restart(input logic [1:0] s);
    pg = '0;
    step(10);
    sel = s;
    pg = '1;
  endtask

  initial begin
    step(5);
    check("R1 during reset", 1'b0);
    rst = 1'b0;
    step(3);
    check("R1 after reset", 1'b0);

    // R2: one channel good at a time, never released
    pg = 2'b01;
    hold_check("R2 ch1 bad", 400, 1'b0);
    pg = 2'b10;
    hold_check("R2 ch0 bad", 400, 1'b0);

    // R3 / R4: every delay code
    for (int s = 0; s < 4; s++) begin
      restart(2'(s));
      release_check($sformatf("R3 R4 code %0d", s), 2'(s), 0);
    end

    // R7: random drops during count and after release
    for (int it = 0; it < 6; it++) begin
      logic [1:0] s = 2'($urandom % 2);
      int k;
      restart(s);
      k = 20 + int'($urandom % 100);
      step(k);
      check("R7 counting", 1'b0);
      pg = 2'($urandom % 3);
      step(5);
      check("R7 drop in count", 1'b0);
      step(1 + int'($urandom % 20));
      pg = '1;
      release_check("R7 restart", s, 0);
      pg = (($urandom % 2) == 0) ? 2'b01 : 2'b10;
      step(5);
      check("R7 drop after release", 1'b0);
      pg = '1;
      release_check("R7 rerelease", s, 0);
    end

    // R9: select change during count is ignored
    restart(2'b00);
    step(20);
    sel = 2'b11;
    release_check("R9 late select", 2'b00, 20);
    sel = 2'b00;

    // R6: short manual pulses ignored
    for (int it = 0; it < 6; it++) begin
      int w = 1 + int'($urandom % (MRC - 1));
      mr = 1'b1;
      step(w);
      mr = 1'b0;
      hold_check("R6 short pulse", 20, 1'b1);
    end
    mr = 1'b1;
    step(MRC - 1);
    mr = 1'b0;
    hold_check("R6 boundary short", 20, 1'b1);

    // R5 / R8: long pulse
    mr = 1'b1;
    step(MRC + 5);
    check("R5 long pulse", 1'b0);
    hold_check("R5 held", 30, 1'b0);
    mr = 1'b0;
    release_check("R8 after pulse", 2'b00, 0);

    // R5 / R8: pulse of exactly the minimum width
    mr = 1'b1;
    step(MRC);
    mr = 1'b0;
    step(5);
    check("R5 boundary pulse", 1'b0);
    release_check("R8 boundary", 2'b00, 5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog R1-all: state=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

endmodule